// File: doc/BRIEF.md
# Line-Based Dataflow Prescheduler

This block sits between decode and a small issue buffer and replaces associative wakeup with timing bookkeeping. A circular array of issue lines is kept, and each line stands for one future scheduling step. A per-register table records how many lines ahead of the active line each architectural register's value becomes available. An incoming instruction goes into the line given by the later of its two source operands. Its destination register is then marked available that many lines plus the instruction's latency ahead.

Each cycle the block presents the oldest instruction of the active line on a valid/ready stream. The active pointer moves on by one line in any cycle where the active line is empty and is not being written. When the issue buffer pushes back, the line cannot drain and the pointer waits. A full target line makes the instruction spill forward to the next line with room. If no line up to the far end of the window has room, dispatch is refused.

Top module: `line_presched`

## Requirements
- R1: After reset every line is empty and every register is available at the active line: `out_valid_o` is 0, and `in_ready_o` is 1 for any source registers.
- R2: An instruction's target offset, counted in lines from the active line, is the larger of its two source registers' remaining distances. Offset 0 means the active line.
- R3: An accepted instruction placed at offset k with latency L sets its destination register's distance to k+L. When the pointer moves in that same cycle, the value is k+L-1. A dependent placed later uses this value.
- R4: The active pointer advances by one line, wrapping after the last line, exactly in cycles where the active line is empty and no instruction is placed into it. Every nonzero register distance then drops by one.
- R5: Only the active line's instructions are presented on the output, one per cycle and oldest first. The output fields repeat the accepted instruction's tag, sources, destination and latency.
- R6: A line never holds more than LINE_W instructions. When the target line is full, the instruction goes into the nearest following line that has room.
- R7: When no line from the target offset up to offset NUM_LINES-1 has room, `in_ready_o` is 0 and nothing is stored.
- R8: While the output is valid and `out_ready_i` is 0, the same instruction stays on the output and the active pointer does not move.
- R9: A target offset larger than NUM_LINES-1 is clamped to NUM_LINES-1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Decoded instruction present |
| in_ready_o | output | 1 | Instruction accepted this cycle when valid |
| in_src_a_i | input | REG_W | First source register |
| in_src_b_i | input | REG_W | Second source register |
| in_dst_i | input | REG_W | Destination register |
| in_lat_i | input | LAT_W | Execution latency in cycles |
| in_tag_i | input | TAG_W | Opaque instruction tag |
| out_valid_o | output | 1 | Active line holds an instruction |
| out_ready_i | input | 1 | Issue buffer takes the presented instruction |
| out_src_a_o | output | REG_W | First source of presented instruction |
| out_src_b_o | output | REG_W | Second source of presented instruction |
| out_dst_o | output | REG_W | Destination of presented instruction |
| out_lat_o | output | LAT_W | Latency of presented instruction |
| out_tag_o | output | TAG_W | Tag of presented instruction |

## Verification
Short dependence chains with large latencies show whether an instruction lands at the later of its operands' lines and not the earlier one. One chain is long enough to reach past the window, which exercises the clamp. Bursts of independent instructions while the issue buffer refuses everything fill one line and then the whole window. They separate correct spilling and a refused dispatch from overwriting or loss. Idle gaps of varying length test pointer advance and the countdown of distances. A long random mix of sources, latencies and backpressure then compares the order of output tags against a bench model.

// File: rtl/lps_pkg.sv
package lps_pkg;
  localparam int unsigned DEF_NUM_REGS  = 16;
  localparam int unsigned DEF_NUM_LINES = 12;
  localparam int unsigned DEF_LINE_W    = 2;
  localparam int unsigned DEF_LAT_W     = 3;
  localparam int unsigned DEF_TAG_W     = 8;
endpackage

// File: rtl/lps_reg_table.sv
module lps_reg_table #(
  parameter int unsigned NUM_REGS = 16,
  parameter int unsigned REG_W    = 4,
  parameter int unsigned DIST_W   = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [REG_W-1:0]  rd_a_i,
  input  logic [REG_W-1:0]  rd_b_i,
  output logic [DIST_W-1:0] dist_a_o,
  output logic [DIST_W-1:0] dist_b_o,
  input  logic              shift_i,
  input  logic              wr_en_i,
  input  logic [REG_W-1:0]  wr_reg_i,
  input  logic [DIST_W-1:0] wr_dist_i
);
  logic [NUM_REGS-1:0][DIST_W-1:0] dist_q;

  assign dist_a_o = dist_q[rd_a_i];
  assign dist_b_o = dist_q[rd_b_i];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dist_q <= '0;
    end else begin
      for (int r = 0; r < NUM_REGS; r++) begin
        if (wr_en_i && wr_reg_i == REG_W'(r)) begin
          dist_q[r] <= wr_dist_i;
        end else if (shift_i && dist_q[r] != '0) begin
          dist_q[r] <= dist_q[r] - 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/lps_line.sv
module lps_line #(
  parameter int unsigned LINE_W = 2,
  parameter int unsigned CNT_W  = 2,
  parameter type         entry_t = logic [7:0]
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             push_i,
  input  entry_t           din_i,
  input  logic             pop_i,
  output entry_t           head_o,
  output logic [CNT_W-1:0] cnt_o
);
  entry_t [LINE_W-1:0] slots_q, slots_d;
  logic   [CNT_W-1:0]  cnt_q, cnt_d;

  always_comb begin
    slots_d = slots_q;
    cnt_d   = cnt_q;
    if (pop_i) begin
      for (int i = 0; i < LINE_W - 1; i++) slots_d[i] = slots_q[i+1];
      cnt_d = cnt_q - 1'b1;
    end
    if (push_i) begin
      for (int i = 0; i < LINE_W; i++) begin
        if (cnt_d == CNT_W'(i)) slots_d[i] = din_i;
      end
      cnt_d = cnt_d + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      slots_q <= '0;
      cnt_q   <= '0;
    end else begin
      slots_q <= slots_d;
      cnt_q   <= cnt_d;
    end
  end

  assign head_o = slots_q[0];
  assign cnt_o  = cnt_q;
endmodule

// File: rtl/lps_place.sv
module lps_place #(
  parameter int unsigned NUM_LINES = 12,
  parameter int unsigned LINE_W    = 2,
  parameter int unsigned OFF_W     = 4,
  parameter int unsigned CNT_W     = 2
) (
  input  logic [NUM_LINES-1:0][CNT_W-1:0] cnt_i,
  input  logic [OFF_W-1:0]                act_i,
  input  logic [OFF_W-1:0]                base_i,
  output logic                            found_o,
  output logic [OFF_W-1:0]                off_o,
  output logic [OFF_W-1:0]                phys_o
);
  // first offset at or beyond base whose physical line has room
  always_comb begin
    logic [OFF_W:0] p;
    found_o = 1'b0;
    off_o   = '0;
    phys_o  = '0;
    for (int k = 0; k < NUM_LINES; k++) begin
      p = {1'b0, act_i} + (OFF_W+1)'(k);
      if (p >= (OFF_W+1)'(NUM_LINES)) p = p - (OFF_W+1)'(NUM_LINES);
      if (!found_o && OFF_W'(k) >= base_i &&
          cnt_i[p[OFF_W-1:0]] < CNT_W'(LINE_W)) begin
        found_o = 1'b1;
        off_o   = OFF_W'(k);
        phys_o  = p[OFF_W-1:0];
      end
    end
  end
endmodule

// File: rtl/line_presched.sv
module line_presched
  import lps_pkg::*;
#(
  parameter int unsigned NUM_REGS  = DEF_NUM_REGS,
  parameter int unsigned NUM_LINES = DEF_NUM_LINES,
  parameter int unsigned LINE_W    = DEF_LINE_W,
  parameter int unsigned LAT_W     = DEF_LAT_W,
  parameter int unsigned TAG_W     = DEF_TAG_W,
  localparam int unsigned REG_W    = $clog2(NUM_REGS),
  localparam int unsigned OFF_W    = $clog2(NUM_LINES),
  localparam int unsigned CNT_W    = $clog2(LINE_W + 1),
  localparam int unsigned DIST_W   = $clog2(NUM_LINES + (1 << LAT_W))
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             in_valid_i,
  output logic             in_ready_o,
  input  logic [REG_W-1:0] in_src_a_i,
  input  logic [REG_W-1:0] in_src_b_i,
  input  logic [REG_W-1:0] in_dst_i,
  input  logic [LAT_W-1:0] in_lat_i,
  input  logic [TAG_W-1:0] in_tag_i,
  output logic             out_valid_o,
  input  logic             out_ready_i,
  output logic [REG_W-1:0] out_src_a_o,
  output logic [REG_W-1:0] out_src_b_o,
  output logic [REG_W-1:0] out_dst_o,
  output logic [LAT_W-1:0] out_lat_o,
  output logic [TAG_W-1:0] out_tag_o
);
  typedef struct packed {
    logic [TAG_W-1:0] tag;
    logic [LAT_W-1:0] lat;
    logic [REG_W-1:0] dst;
    logic [REG_W-1:0] src_b;
    logic [REG_W-1:0] src_a;
  } entry_t;

  logic [OFF_W-1:0]                act_q;
  logic [NUM_LINES-1:0][CNT_W-1:0] line_cnt;
  entry_t [NUM_LINES-1:0]          heads;
  logic [NUM_LINES-1:0]            push, pop;

  logic [DIST_W-1:0] dist_a, dist_b, dist_max, wr_dist;
  logic [OFF_W-1:0]  base_off, place_off, place_phys;
  logic              found, accept, out_fire, advance;
  entry_t            in_entry, head;

  lps_reg_table #(
    .NUM_REGS(NUM_REGS), .REG_W(REG_W), .DIST_W(DIST_W)
  ) i_reg_table (
    .clk_i, .rst_ni,
    .rd_a_i   (in_src_a_i),
    .rd_b_i   (in_src_b_i),
    .dist_a_o (dist_a),
    .dist_b_o (dist_b),
    .shift_i  (advance),
    .wr_en_i  (accept),
    .wr_reg_i (in_dst_i),
    .wr_dist_i(wr_dist)
  );

  // later operand wins; clamp to far end of window
  assign dist_max = (dist_a > dist_b) ? dist_a : dist_b;
  assign base_off = (dist_max > DIST_W'(NUM_LINES - 1)) ? OFF_W'(NUM_LINES - 1)
                                                        : dist_max[OFF_W-1:0];

  lps_place #(
    .NUM_LINES(NUM_LINES), .LINE_W(LINE_W), .OFF_W(OFF_W), .CNT_W(CNT_W)
  ) i_place (
    .cnt_i  (line_cnt),
    .act_i  (act_q),
    .base_i (base_off),
    .found_o(found),
    .off_o  (place_off),
    .phys_o (place_phys)
  );

  assign in_ready_o = found;
  assign accept     = in_valid_i && found;
  assign in_entry   = '{tag: in_tag_i, lat: in_lat_i, dst: in_dst_i,
                        src_b: in_src_b_i, src_a: in_src_a_i};

  assign out_valid_o = line_cnt[act_q] != '0;
  assign out_fire    = out_valid_o && out_ready_i;
  assign head        = heads[act_q];
  assign advance     = !out_valid_o && !(accept && place_off == '0);
  assign wr_dist     = DIST_W'(place_off) + DIST_W'(in_lat_i) - DIST_W'(advance);

  for (genvar l = 0; l < NUM_LINES; l++) begin : g_line
    assign push[l] = accept && place_phys == OFF_W'(l);
    assign pop[l]  = out_fire && act_q == OFF_W'(l);
    lps_line #(
      .LINE_W(LINE_W), .CNT_W(CNT_W), .entry_t(entry_t)
    ) i_line (
      .clk_i, .rst_ni,
      .push_i(push[l]),
      .din_i (in_entry),
      .pop_i (pop[l]),
      .head_o(heads[l]),
      .cnt_o (line_cnt[l])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q <= '0;
    end else if (advance) begin
      act_q <= (act_q == OFF_W'(NUM_LINES - 1)) ? '0 : act_q + 1'b1;
    end
  end

  assign out_src_a_o = head.src_a;
  assign out_src_b_o = head.src_b;
  assign out_dst_o   = head.dst;
  assign out_lat_o   = head.lat;
  assign out_tag_o   = head.tag;
endmodule

// File: rtl/lps_checker.sv
module lps_checker #(
  parameter int unsigned NUM_LINES = 12,
  parameter int unsigned LINE_W    = 2,
  parameter int unsigned TAG_W     = 8,
  parameter int unsigned OFF_W     = 4,
  parameter int unsigned CNT_W     = 2
) (
  input logic                            clk_i,
  input logic                            rst_ni,
  input logic                            in_valid_i,
  input logic                            in_ready_o,
  input logic                            out_valid_o,
  input logic                            out_ready_i,
  input logic [TAG_W-1:0]                out_tag_o,
  input logic [OFF_W-1:0]                act_q,
  input logic [NUM_LINES-1:0][CNT_W-1:0] line_cnt
);
  localparam int unsigned OCC_W = $clog2(NUM_LINES * LINE_W + 1);

  logic [OCC_W-1:0] occ;
  logic [OFF_W-1:0] act_nxt;

  always_comb begin
    occ = '0;
    for (int l = 0; l < NUM_LINES; l++) occ = occ + OCC_W'(line_cnt[l]);
  end
  assign act_nxt = (act_q == OFF_W'(NUM_LINES - 1)) ? '0 : act_q + 1'b1;

  for (genvar l = 0; l < NUM_LINES; l++) begin : g_cap
    assert_line_cap_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      line_cnt[l] <= CNT_W'(LINE_W));
  end

  assert_no_store_when_refused_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !in_ready_o |=> occ <= $past(occ));

  assert_out_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && !out_ready_i) |=> (out_valid_o && $stable(out_tag_o) && $stable(act_q)));

  assert_ptr_step_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (line_cnt[act_q] == '0 && !(in_valid_i && in_ready_o)) |=> act_q == $past(act_nxt));

  assert_ptr_wait_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (line_cnt[act_q] != '0) |=> $stable(act_q));
endmodule

bind line_presched lps_checker #(
  .NUM_LINES(NUM_LINES), .LINE_W(LINE_W), .TAG_W(TAG_W), .OFF_W(OFF_W), .CNT_W(CNT_W)
) i_lps_checker (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .in_valid_i (in_valid_i),
  .in_ready_o (in_ready_o),
  .out_valid_o(out_valid_o),
  .out_ready_i(out_ready_i),
  .out_tag_o  (out_tag_o),
  .act_q      (act_q),
  .line_cnt   (line_cnt)
);

// File: tb/test_line_presched.sv
`timescale 1ns/1ps
module test_line_presched;
  localparam int NR = 16;
  localparam int NL = 12;
  localparam int LW = 2;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       in_valid = 1'b0, out_ready = 1'b0;
  logic [3:0] src_a = '0, src_b = '0, dst = '0;
  logic [2:0] lat = '0;
  logic [7:0] tag = '0;
  logic       in_ready, out_valid;
  logic [3:0] o_src_a, o_src_b, o_dst;
  logic [2:0] o_lat;
  logic [7:0] o_tag;

  always #2 clk = ~clk;

  line_presched i_line_presched (
    .clk_i(clk), .rst_ni(rst_n),
    .in_valid_i(in_valid), .in_ready_o(in_ready),
    .in_src_a_i(src_a), .in_src_b_i(src_b), .in_dst_i(dst),
    .in_lat_i(lat), .in_tag_i(tag),
    .out_valid_o(out_valid), .out_ready_i(out_ready),
    .out_src_a_o(o_src_a), .out_src_b_o(o_src_b), .out_dst_o(o_dst),
    .out_lat_o(o_lat), .out_tag_o(o_tag)
  );

  int    n_checks = 0, n_fail = 0;
  string req = "R1";
  int    m_dist[NR];
  int    m_cnt[NL];
  int    m_tag[NL][LW];
  int    m_dst[NL][LW];
  int    m_act = 0;
  int    next_tag = 0;
  bit    done = 0;

  task automatic chk(string r, string what, int actual, int expected);
    n_checks++;
    if (actual != expected) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d", r, what, actual, expected);
    end
  endtask

  function automatic int model_base(int a, int b);
    int m = (m_dist[a] > m_dist[b]) ? m_dist[a] : m_dist[b];
    return (m > NL - 1) ? NL - 1 : m;
  endfunction

  task automatic step(input bit v, input int a, input int b, input int d,
                      input int l, input bit ordy);
    int  base, kf, pf;
    bit  found, ov, acc, adv;
    @(negedge clk);
    in_valid = v; src_a = 4'(a); src_b = 4'(b); dst = 4'(d);
    lat = 3'(l); tag = 8'(next_tag); out_ready = ordy;
    #1;
    base = model_base(a, b);
    found = 0; kf = 0; pf = 0;
    for (int k = base; k < NL; k++) begin
      int p = (m_act + k) % NL;
      if (!found && m_cnt[p] < LW) begin found = 1; kf = k; pf = p; end
    end
    chk(req, "in_ready", int'(in_ready), int'(found));
    ov = m_cnt[m_act] > 0;
    chk(req, "out_valid", int'(out_valid), int'(ov));
    if (ov) begin
      chk(req, "out_tag", int'(o_tag), m_tag[m_act][0]);
      chk(req, "out_dst", int'(o_dst), m_dst[m_act][0]);
    end
    acc = v && found;
    adv = (m_cnt[m_act] == 0) && !(acc && kf == 0);
    if (ov && ordy) begin
      for (int i = 0; i < LW - 1; i++) begin
        m_tag[m_act][i] = m_tag[m_act][i+1];
        m_dst[m_act][i] = m_dst[m_act][i+1];
      end
      m_cnt[m_act]--;
    end
    if (acc) begin
      m_tag[pf][m_cnt[pf]] = next_tag;
      m_dst[pf][m_cnt[pf]] = d;
      m_cnt[pf]++;
    end
    if (adv) for (int r = 0; r < NR; r++) if (m_dist[r] > 0) m_dist[r]--;
    if (acc) begin
      m_dist[d] = kf + l - (adv ? 1 : 0);
      next_tag = (next_tag + 1) % 256;
    end
    if (adv) m_act = (m_act + 1) % NL;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(0, 0, 0, 0, 0, 1);
  endtask

  initial begin
    int cyc = 0;
    while (!done) begin
      @(posedge clk);
      cyc++;
      if (cyc > 150000) begin
        n_fail++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
      end
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int r = 0; r < NR; r++) m_dist[r] = 0;
    for (int l = 0; l < NL; l++) m_cnt[l] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); #1;
    // R1: empty after reset, any sources accepted
    chk("R1", "out_valid_after_reset", int'(out_valid), 0);
    src_a = 4'd7; src_b = 4'd15; #1;
    chk("R1", "in_ready_after_reset", int'(in_ready), 1);

    // R2: consumer lands at the later operand
    req = "R2";
    step(1, 1, 2, 3, 4, 1);
    step(1, 3, 0, 5, 1, 1);
    step(1, 0, 3, 6, 2, 1);
    idle(20);

    // R3: chain through destination distances
    req = "R3";
    step(1, 0, 0, 4, 6, 1);
    step(1, 4, 4, 6, 2, 1);
    step(1, 6, 0, 7, 1, 1);
    step(1, 7, 4, 8, 0, 1);
    idle(25);

    // R4: idle advance then placement
    req = "R4";
    idle(5);
    step(1, 0, 0, 9, 3, 1);
    idle(2);
    step(1, 9, 0, 10, 1, 1);
    idle(15);

    // R6: three ready instructions, line holds two
    req = "R6";
    step(1, 0, 0, 1, 1, 0);
    step(1, 0, 0, 2, 1, 0);
    step(1, 0, 0, 3, 1, 0);
    idle(15);

    // R7: whole window fills while output is blocked
    req = "R7";
    for (int i = 0; i < NL * LW + 3; i++) step(1, 11, 12, 13, 1, 0);
    idle(40);

    // R8: backpressure holds output and pointer
    req = "R8";
    step(1, 0, 0, 2, 1, 0);
    step(1, 0, 0, 3, 1, 0);
    for (int i = 0; i < 4; i++) step(0, 0, 0, 0, 0, 0);
    idle(10);

    // R9: chain past window end is clamped
    req = "R9";
    step(1, 0, 0, 12, 7, 1);
    step(1, 12, 12, 13, 7, 1);
    step(1, 13, 0, 14, 1, 1);
    step(1, 14, 13, 15, 0, 1);
    idle(40);

    // R5: random mix
    req = "R5";
    for (int i = 0; i < 800; i++) begin
      step(($urandom % 10) < 7, $urandom % NR, $urandom % NR, $urandom % NR,
           $urandom % 8, ($urandom % 10) < 8);
    end
    idle(60);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end
endmodule